// File: doc/BRIEF.md
# Operate Instruction Execute Unit

This block is the arithmetic and logic execute stage of a small 16-bit load/store processor with eight 16-bit general registers. Each cycle it takes one instruction word with a valid strobe, decodes it, and handles the three register-writing operate instructions: addition, bitwise AND and bitwise complement. The register file lives inside the block. The result is written back at the next clock edge, and the three condition flags (negative, zero, positive) are loaded from that result.

The block also evaluates conditional branches against the stored flags and raises a branch-taken signal that the fetch logic uses. Target address computation, memory traffic and instruction fetch belong to other blocks. The write-back value and its enable appear on ports so that the pipeline around the block can observe them.

Top module: `opx_unit`

## Requirements
- R1: After reset every register reads 0 and `cc_flags` is 3'b010. Flag encoding is bit 2 = N, bit 1 = Z, bit 0 = P.
- R2: The register form of addition is opcode 0001 in [15:12] with bit 5 = 0. It gives `wb_data` = reg[[8:6]] + reg[[2:0]] modulo 2^16, with destination [11:9]. Overflow wraps silently and no overflow flag exists.
- R3: When bit 5 = 1 in an add or AND instruction, the second operand is bits [4:0] read as two's complement (-16..+15) and sign-extended to 16 bits.
- R4: Opcode 0101 gives `wb_data` = reg[[8:6]] AND the second operand. The operand is selected as in R2 and R3.
- R5: Opcode 1001 with [5:0] = 111111 gives `wb_data` = bitwise complement of reg[[8:6]]. If [5:0] holds any other value, the instruction does not write a register and does not change the flags.
- R6: `wb_en` is high in the same cycle as a valid operate instruction, and the destination register takes `wb_data` at the next rising edge. Reading the register that is being written in that same cycle returns its old value.
- R7: After every write, from the next cycle on, exactly one flag is set. N is set if bit 15 of the result is 1, Z if the result is 0, and P otherwise.
- R8: Opcode 0000 is a branch with its n, z and p mask in bits [11], [10] and [9]. `br_taken` = `instr_vld` AND (any mask bit whose flag is set). It reacts combinationally to the current flags. A branch never writes a register and never changes the flags.
- R9: When `instr_vld` is low, or when the opcode is any other value, there is no write, no flag change, and `br_taken` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_vld | input | 1 | Instruction word is valid this cycle |
| instr | input | 16 | Instruction word |
| wb_data | output | 16 | Result to be written back |
| wb_en | output | 1 | Register write happens at the next edge |
| cc_flags | output | 3 | Stored flags {N,Z,P} |
| br_taken | output | 1 | Current branch instruction is taken |

## Verification
The assertions assume that `instr_vld` and `instr` hold known values whenever reset is released, and that they change only away from the rising edge. The bench meets this by driving every input from falling edges and by holding reset low from time zero. Under those conditions the flags are always one-hot, so a branch with mask 111 must always be taken. The stimulus therefore mixes directed sequences with a random stream of operate, branch, malformed-complement and unknown instructions, so that every flag state meets every mask.

// File: rtl/opx_pkg.sv
package opx_pkg;
  localparam int XLEN  = 16;
  localparam int IMM_W = 5;

  localparam logic [3:0] OPC_BR  = 4'b0000;
  localparam logic [3:0] OPC_ADD = 4'b0001;
  localparam logic [3:0] OPC_AND = 4'b0101;
  localparam logic [3:0] OPC_NOT = 4'b1001;

  typedef enum logic [1:0] {ALU_ADD, ALU_AND, ALU_INV} alu_e;

  typedef struct packed {
    logic n;
    logic z;
    logic p;
  } cc_t;

  function automatic logic [XLEN-1:0] sext_imm(input logic [IMM_W-1:0] v);
    return {{(XLEN-IMM_W){v[IMM_W-1]}}, v};
  endfunction

  function automatic cc_t cc_of(input logic [XLEN-1:0] v);
    cc_t c;
    c.n = v[XLEN-1];
    c.z = (v == '0);
    c.p = !v[XLEN-1] && (v != '0);
    return c;
  endfunction

  function automatic logic [XLEN-1:0] alu_eval(input alu_e op,
                                               input logic [XLEN-1:0] a,
                                               input logic [XLEN-1:0] b);
    case (op)
      ALU_ADD: return a + b;
      ALU_AND: return a & b;
      default: return ~a;
    endcase
  endfunction
endpackage

// File: rtl/opx_decode.sv
module opx_decode
  import opx_pkg::*;
#(
  parameter int AW = 3
) (
  input  logic             vld,
  input  logic [XLEN-1:0]  instr,
  output logic [AW-1:0]    dst,
  output logic [AW-1:0]    src1,
  output logic [AW-1:0]    src2,
  output logic             use_imm,
  output logic [IMM_W-1:0] imm,
  output alu_e             op,
  output logic             wr_req,
  output logic             is_br,
  output logic [2:0]       br_mask
);
  logic [3:0] opc;
  logic       not_ok;

  assign opc     = instr[15:12];
  assign dst     = instr[11:9];
  assign src1    = instr[8:6];
  assign use_imm = instr[5];
  assign imm     = instr[4:0];
  assign src2    = instr[2:0];
  assign br_mask = instr[11:9];
  assign not_ok  = (instr[5:0] == 6'b111111);

  always_comb begin
    op     = ALU_ADD;
    wr_req = 1'b0;
    is_br  = 1'b0;
    if (vld) begin
      case (opc)
        OPC_ADD: begin op = ALU_ADD; wr_req = 1'b1; end
        OPC_AND: begin op = ALU_AND; wr_req = 1'b1; end
        OPC_NOT: begin op = ALU_INV; wr_req = not_ok; end
        OPC_BR:  is_br = 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/opx_regfile.sv
module opx_regfile
  import opx_pkg::*;
#(
  parameter int DATA_W = XLEN,
  parameter int NREG   = 8,
  localparam int AW    = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     ra0,
  output logic [DATA_W-1:0] rd0,
  input  logic [AW-1:0]     ra1,
  output logic [DATA_W-1:0] rd1,
  input  logic              we,
  input  logic [AW-1:0]     wa,
  input  logic [DATA_W-1:0] wd
);
  logic [DATA_W-1:0] mem [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    mem[i] <= '0;
      else if (we && wa == AW'(i))   mem[i] <= wd;
    end
  end

  assign rd0 = mem[ra0];
  assign rd1 = mem[ra1];
endmodule

// File: rtl/opx_alu.sv
module opx_alu
  import opx_pkg::*;
(
  input  alu_e             op,
  input  logic [XLEN-1:0]  a,
  input  logic [XLEN-1:0]  b_reg,
  input  logic [IMM_W-1:0] imm,
  input  logic             use_imm,
  output logic [XLEN-1:0]  y
);
  logic [XLEN-1:0] b;
  assign b = use_imm ? sext_imm(imm) : b_reg;
  assign y = alu_eval(op, a, b);
endmodule

// File: rtl/opx_ccr.sv
module opx_ccr
  import opx_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            upd,
  input  logic [XLEN-1:0] res,
  input  logic            is_br,
  input  logic [2:0]      mask,
  output logic [2:0]      flags,
  output logic            take
);
  cc_t cc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cc_q <= '{n: 1'b0, z: 1'b1, p: 1'b0};
    else if (upd) cc_q <= cc_of(res);
  end

  assign flags = cc_q;
  assign take  = is_br && |(mask & flags);
endmodule

// File: rtl/opx_unit.sv
module opx_unit
  import opx_pkg::*;
#(
  parameter int NREG = 8,
  localparam int AW  = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            instr_vld,
  input  logic [XLEN-1:0] instr,
  output logic [XLEN-1:0] wb_data,
  output logic            wb_en,
  output logic [2:0]      cc_flags,
  output logic            br_taken
);
  logic [AW-1:0]    dec_dst, dec_src1, dec_src2;
  logic             dec_use_imm, dec_wr, dec_is_br;
  logic [IMM_W-1:0] dec_imm;
  logic [2:0]       dec_mask;
  alu_e             dec_op;
  logic [XLEN-1:0]  rf_a, rf_b, alu_y;

  opx_decode #(.AW(AW)) u_dec (
    .vld(instr_vld), .instr(instr), .dst(dec_dst), .src1(dec_src1),
    .src2(dec_src2), .use_imm(dec_use_imm), .imm(dec_imm), .op(dec_op),
    .wr_req(dec_wr), .is_br(dec_is_br), .br_mask(dec_mask)
  );

  opx_regfile #(.DATA_W(XLEN), .NREG(NREG)) u_rf (
    .clk(clk), .rst_n(rst_n), .ra0(dec_src1), .rd0(rf_a),
    .ra1(dec_src2), .rd1(rf_b), .we(dec_wr), .wa(dec_dst), .wd(alu_y)
  );

  opx_alu u_alu (
    .op(dec_op), .a(rf_a), .b_reg(rf_b), .imm(dec_imm),
    .use_imm(dec_use_imm), .y(alu_y)
  );

  opx_ccr u_cc (
    .clk(clk), .rst_n(rst_n), .upd(dec_wr), .res(alu_y),
    .is_br(dec_is_br), .mask(dec_mask), .flags(cc_flags), .take(br_taken)
  );

  assign wb_data = alu_y;
  assign wb_en   = dec_wr;
endmodule

// File: rtl/opx_unit_chk.sv
module opx_unit_chk
  import opx_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            instr_vld,
  input logic [3:0]      instr_op,
  input logic [5:0]      instr_lo,
  input logic [XLEN-1:0] wb_data,
  input logic            wb_en,
  input logic [2:0]      cc_flags,
  input logic            br_taken,
  input logic            dec_is_br
);
  logic known_op;
  assign known_op = (instr_op == OPC_ADD) || (instr_op == OPC_AND) ||
                    (instr_op == OPC_NOT) || (instr_op == OPC_BR);

  // R1: first cycle after reset release shows Z only
  a_r1_reset_flags: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> cc_flags == 3'b010);

  // R7: flags are always one-hot
  a_r7_onehot_flags: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(cc_flags) == 1);

  // R7: flags follow the written value
  a_r7_flags_follow: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |=> cc_flags == cc_of($past(wb_data)));

  // R8: a branch leaves the flags alone and never writes
  a_r8_br_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_vld && instr_op == OPC_BR) |=> $stable(cc_flags));

  a_r8_br_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    dec_is_br |-> !wb_en);

  a_r8_taken_only_br: assert property (@(posedge clk) disable iff (!rst_n)
    br_taken |-> (instr_vld && instr_op == OPC_BR));

  // R5: malformed complement does not write
  a_r5_bad_not: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_op == OPC_NOT && instr_lo != 6'b111111) |-> !wb_en);

  // R9: idle or unknown opcode does nothing
  a_r9_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!instr_vld || !known_op) |-> (!wb_en && !br_taken));

  a_r9_idle_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (!instr_vld || !known_op) |=> $stable(cc_flags));
endmodule

bind opx_unit opx_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .instr_vld(instr_vld),
  .instr_op(instr[15:12]), .instr_lo(instr[5:0]),
  .wb_data(wb_data), .wb_en(wb_en), .cc_flags(cc_flags),
  .br_taken(br_taken), .dec_is_br(dec_is_br)
);

// File: tb/opx_unit_tb.sv
module opx_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        instr_vld = 1'b0;
  logic [15:0] instr = 16'h0;
  logic [15:0] wb_data;
  logic        wb_en;
  logic [2:0]  cc_flags;
  logic        br_taken;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [15:0] m_reg [8];
  logic [2:0]  m_cc;

  always #10 clk = ~clk;

  opx_unit u_dut (
    .clk(clk), .rst_n(rst_n), .instr_vld(instr_vld), .instr(instr),
    .wb_data(wb_data), .wb_en(wb_en), .cc_flags(cc_flags), .br_taken(br_taken)
  );

  function automatic logic [15:0] e_addr(input int d, input int a, input int b);
    return {4'b0001, 3'(d), 3'(a), 3'b000, 3'(b)};
  endfunction
  function automatic logic [15:0] e_addi(input int d, input int a, input int k);
    return {4'b0001, 3'(d), 3'(a), 1'b1, 5'(k)};
  endfunction
  function automatic logic [15:0] e_andr(input int d, input int a, input int b);
    return {4'b0101, 3'(d), 3'(a), 3'b000, 3'(b)};
  endfunction
  function automatic logic [15:0] e_andi(input int d, input int a, input int k);
    return {4'b0101, 3'(d), 3'(a), 1'b1, 5'(k)};
  endfunction
  function automatic logic [15:0] e_not(input int d, input int a);
    return {4'b1001, 3'(d), 3'(a), 6'b111111};
  endfunction
  function automatic logic [15:0] e_br(input int m);
    return {4'b0000, 3'(m), 9'h055};
  endfunction

  task automatic chk(input string rq, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h instr=%h", rq, act, exp, instr);
    end
  endtask

  // one instruction: drive at falling edge, compare mid-low, update model at edge
  task automatic step(input logic v, input logic [15:0] ins);
    int op, k;
    logic [15:0] a, b, val;
    logic we, tk;
    string rq;
    @(negedge clk);
    instr_vld = v;
    instr = ins;
    #5;
    op = int'(ins[15:12]);
    a = m_reg[ins[8:6]];
    k = int'(ins[4:0]);
    if (k > 15) k = k - 32;
    b = ins[5] ? 16'(k) : m_reg[ins[2:0]];
    we = 1'b0; tk = 1'b0; val = 16'h0; rq = "R9";
    if (v) begin
      if (op == 1) begin
        val = 16'((int'(a) + int'(b)) % 65536); we = 1'b1;
        rq = ins[5] ? "R3" : "R2";
      end else if (op == 5) begin
        val = a & b; we = 1'b1; rq = ins[5] ? "R3" : "R4";
      end else if (op == 9) begin
        rq = "R5";
        if (ins[5:0] == 6'b111111) begin val = ~a; we = 1'b1; end
      end else if (op == 0) begin
        rq = "R8";
        tk = (ins[11] && m_cc[2]) || (ins[10] && m_cc[1]) || (ins[9] && m_cc[0]);
      end
    end
    chk("R7 flags", {13'h0, cc_flags}, {13'h0, m_cc});
    chk({rq, " R6 wb_en"}, {15'h0, wb_en}, {15'h0, we});
    chk({rq, " br_taken"}, {15'h0, br_taken}, {15'h0, tk});
    if (we) chk({rq, " wb_data"}, wb_data, val);
    @(posedge clk);
    if (we) begin
      m_reg[ins[11:9]] = val;
      m_cc = val[15] ? 3'b100 : (val == 16'h0 ? 3'b010 : 3'b001);
    end
  endtask

  initial begin
    for (int i = 0; i < 8; i++) m_reg[i] = 16'h0;
    m_cc = 3'b010;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #5;
    chk("R1 reset flags", {13'h0, cc_flags}, 16'h0002);
    chk("R1 reset idle wb_en", {15'h0, wb_en}, 16'h0);
    // R1: every register reads zero
    for (int r = 0; r < 8; r++) step(1'b1, e_addi(r, r, 0));
    // R3: immediate extremes
    step(1'b1, e_addi(1, 1, 15));
    step(1'b1, e_addi(2, 2, -16));
    step(1'b1, e_addi(3, 1, -1));
    // R2: register add, R4: and with register and immediate
    step(1'b1, e_addr(4, 1, 2));
    step(1'b1, e_andr(5, 2, 4));
    step(1'b1, e_andi(6, 2, -8));
    step(1'b1, e_andi(6, 6, 7));
    // R5: complement, then malformed complement
    step(1'b1, e_not(7, 0));
    step(1'b1, e_not(7, 7));
    step(1'b1, {4'b1001, 3'd1, 3'd0, 6'b011111});
    step(1'b1, e_addi(1, 1, 0));
    // R6: back-to-back read of the register just written
    for (int i = 0; i < 4; i++) step(1'b1, e_addi(3, 3, 1));
    // R2: wrap to zero by doubling up to 0x8000 then adding it to itself
    step(1'b1, e_andi(5, 5, 0));
    step(1'b1, e_addi(5, 5, 1));
    for (int i = 0; i < 15; i++) step(1'b1, e_addr(5, 5, 5));
    step(1'b1, e_addr(6, 5, 5));
    // R8: every mask under each flag state
    step(1'b1, e_addi(1, 0, 0));
    for (int m = 0; m < 8; m++) step(1'b1, e_br(m));
    step(1'b1, e_addi(1, 0, -3));
    for (int m = 0; m < 8; m++) step(1'b1, e_br(m));
    step(1'b1, e_addi(1, 0, 9));
    for (int m = 0; m < 8; m++) step(1'b1, e_br(m));
    // R9: not valid, unknown opcodes
    step(1'b0, e_addi(2, 0, 5));
    step(1'b0, e_br(7));
    step(1'b1, 16'h2A45);
    step(1'b1, 16'hF025);
    step(1'b1, e_addi(2, 2, 0));
    // mixed random stream
    for (int i = 0; i < 600; i++) begin
      logic [15:0] w;
      int sel;
      w = 16'($urandom);
      sel = $urandom_range(0, 9);
      case (sel)
        0, 1:    w[15:12] = 4'b0001;
        2, 3:    w[15:12] = 4'b0101;
        4:       begin w[15:12] = 4'b1001; w[5:0] = 6'b111111; end
        5:       w[15:12] = 4'b1001;
        6, 7:    w[15:12] = 4'b0000;
        default: ;
      endcase
      step(($urandom_range(0, 7) != 0), w);
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule